// File: doc/BRIEF.md
# Isochronous Header Quadlet-2 Builder with Frame-Sync Timestamping

This block produces the second quadlet of the common header that precedes every outgoing isochronous packet. Software loads a 30-bit holding register with a 6-bit format code and a 24-bit format-dependent field. The transmit engine asks for one quadlet per packet. The block returns it on the next cycle with a fixed two-bit tag in the top bits.

When timestamping is switched on, the low 16 bits of the format-dependent field are replaced on the way out. The block watches an asynchronous frame-sync input. At the first rising edge seen since the previous packet, it records the low 16 bits of the running cycle timer. The next packet carries that recorded stamp. If no edge arrived since the previous packet, the low 16 bits are sent as all ones. The upper 8 bits of the field are always sent as software wrote them. Issuing a header starts a new observation window.

Top module: `cip_q2_stamper`

## Requirements
- R1: After reset `hdrValid` is 0 and `hdrQuadlet` is 0x00000000, and the holding register holds zero.
- R2: A `hdrReq` sampled at a clock edge makes `hdrValid` high for exactly the following cycle. In that cycle `hdrQuadlet` carries the tag 2'b10 in bits 31..30, the format code in bits 29..24 and the upper field byte in bits 23..16. `hdrQuadlet` holds its value until the next request.
- R3: With `stampEn` low, bits 15..0 of the quadlet equal bits 15..0 of the value written through `regWrData`.
- R4: With `stampEn` high and an edge recorded since the previous header, bits 15..0 equal `cycleTime` as sampled at the clock edge where the rise is detected. Detection happens two synchronizer flops after the input rises, so capture falls on the third clock edge after the input is first sampled high.
- R5: With `stampEn` high and no edge recorded since the previous header, bits 15..0 are 0xFFFF.
- R6: When several rising edges arrive between two headers, the stamp from the first one is kept.
- R7: A rise that is detected in the same cycle as `hdrReq` does not affect the header being issued. It is recorded for the following header.
- R8: Every issued header clears the edge record, so a second header with no new edge carries 0xFFFF when stamping is on.
- R9: A register write (`regWrEn`, `regWrData` bits 29..24 format, 23..0 field) in the same cycle as `hdrReq` leaves the issued header with the previous register contents. Later headers use the new contents.
- R10: Edges are recorded whether or not stamping is enabled. Enabling stamping after an edge makes the next header carry that stamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe for the holding register |
| regWrData | input | 30 | Register value: bits 29..24 format code, bits 23..0 field |
| stampEn | input | 1 | Replace low 16 field bits with stamp or all-ones marker |
| frameSyncIn | input | 1 | Asynchronous frame-sync input |
| cycleTime | input | 16 | Low 16 bits of the running cycle timer |
| hdrReq | input | 1 | One-cycle request for a header quadlet |
| hdrValid | output | 1 | Header quadlet valid, one cycle after the request |
| hdrQuadlet | output | 32 | Header quadlet |

## Verification
The assertions check the following on every cycle:
- the fixed tag on every valid quadlet;
- that the output holds between requests;
- that a detected rise always leaves the edge record set;
- that a request without a coincident rise clears the edge record;
- that the stored stamp cannot change while a record is held;
- that a packet with stamping on and no record carries the all-ones marker.

Only the bench scenarios can show that the stamp equals the cycle-timer value from the exact detection edge. They also cover keeping the first of several edges, deferring an edge that coincides with a request, the ordering of register writes against requests, and edges recorded while stamping is off.

// File: rtl/cipq2_pkg.sv
package cipq2_pkg;
  localparam int QUADLET_W = 32;
  localparam int FMT_W     = 6;
  localparam int FIELD_W   = 24;
  localparam int STAMP_W   = 16;
  localparam int REG_W     = FMT_W + FIELD_W;
  localparam logic [1:0] HDR_TAG = 2'b10;

  typedef struct packed {
    logic capture;   // load stamp register from cycle time
    logic issue;     // build and present a header quadlet
    logic useStamp;  // an edge is recorded for the pending header
  } cipq2_strobe_t;
endpackage

// File: rtl/cipq2_ctrl.sv
module cipq2_ctrl
  import cipq2_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameSyncIn,
  input  logic          hdrReq,
  output cipq2_strobe_t strobe
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] syncChain;
  logic               syncRise;
  logic               edgeSeen;

  always_ff @(posedge clk) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[CHAIN_W-2:0], frameSyncIn};
  end

  assign syncRise = syncChain[SYNC_STAGES-1] & ~syncChain[SYNC_STAGES];

  // A header clears the record; a rise in the same cycle belongs to the next one.
  always_ff @(posedge clk) begin
    if (!rstN)         edgeSeen <= 1'b0;
    else if (hdrReq)   edgeSeen <= syncRise;
    else if (syncRise) edgeSeen <= 1'b1;
  end

  always_comb begin
    strobe.capture  = syncRise & (hdrReq | ~edgeSeen);
    strobe.issue    = hdrReq;
    strobe.useStamp = edgeSeen;
  end

  assert_rise_recorded_R10: assert property (@(posedge clk) disable iff (!rstN)
    syncRise |=> edgeSeen);
  assert_issue_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hdrReq && !syncRise) |=> !edgeSeen);
endmodule

// File: rtl/cipq2_datapath.sv
module cipq2_datapath
  import cipq2_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [REG_W-1:0]     regWrData,
  input  logic                 stampEn,
  input  logic [STAMP_W-1:0]   cycleTime,
  input  cipq2_strobe_t        strobe,
  output logic                 hdrValid,
  output logic [QUADLET_W-1:0] hdrQuadlet
);
  logic [FMT_W-1:0]   fmtReg;
  logic [FIELD_W-1:0] fieldReg;
  logic [STAMP_W-1:0] stampReg;
  logic [STAMP_W-1:0] lowField;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fmtReg   <= '0;
      fieldReg <= '0;
    end else if (regWrEn) begin
      fmtReg   <= regWrData[REG_W-1:FIELD_W];
      fieldReg <= regWrData[FIELD_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               stampReg <= '0;
    else if (strobe.capture) stampReg <= cycleTime;
  end

  always_comb begin
    if (!stampEn)             lowField = fieldReg[STAMP_W-1:0];
    else if (strobe.useStamp) lowField = stampReg;
    else                      lowField = '1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrValid   <= 1'b0;
      hdrQuadlet <= '0;
    end else begin
      hdrValid <= strobe.issue;
      if (strobe.issue)
        hdrQuadlet <= {HDR_TAG, fmtReg, fieldReg[FIELD_W-1:STAMP_W], lowField};
    end
  end

  assert_tag_fixed_R2: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid |-> hdrQuadlet[QUADLET_W-1 -: 2] == HDR_TAG);
  assert_output_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.issue |=> $stable(hdrQuadlet));
  assert_first_stamp_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.useStamp && !strobe.issue) |=> $stable(stampReg));
  assert_marker_no_edge_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && stampEn && !strobe.useStamp) |=> hdrQuadlet[STAMP_W-1:0] == '1);
endmodule

// File: rtl/cip_q2_stamper.sv
module cip_q2_stamper
  import cipq2_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [REG_W-1:0]     regWrData,
  input  logic                 stampEn,
  input  logic                 frameSyncIn,
  input  logic [STAMP_W-1:0]   cycleTime,
  input  logic                 hdrReq,
  output logic                 hdrValid,
  output logic [QUADLET_W-1:0] hdrQuadlet
);
  cipq2_strobe_t strobe;

  cipq2_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameSyncIn(frameSyncIn), .hdrReq(hdrReq), .strobe(strobe)
  );

  cipq2_datapath u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .stampEn(stampEn), .cycleTime(cycleTime), .strobe(strobe),
    .hdrValid(hdrValid), .hdrQuadlet(hdrQuadlet)
  );
endmodule

// File: tb/cip_q2_stamper_tb.sv
module cip_q2_stamper_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [29:0] regWrData = '0;
  logic        stampEn = 1'b0;
  logic        frameSyncIn = 1'b0;
  logic [15:0] cycleTime = '0;
  logic        hdrReq = 1'b0;
  logic        hdrValid;
  logic [31:0] hdrQuadlet;

  int checkCount = 0;
  int failCount = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  cip_q2_stamper u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .stampEn(stampEn), .frameSyncIn(frameSyncIn), .cycleTime(cycleTime),
    .hdrReq(hdrReq), .hdrValid(hdrValid), .hdrQuadlet(hdrQuadlet)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  endtask

  // monitor: compare each produced quadlet against the scoreboard
  always @(negedge clk) begin
    if (rstN && hdrValid) begin
      if (expQ.size() == 0) check("R2 unexpected valid", 32'h1, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, hdrQuadlet, e);
      end
    end
  end

  task automatic writeReg(input logic [29:0] d);
    regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic sendReq(input logic [31:0] exp, input string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    hdrReq = 1'b1;
    @(negedge clk);
    hdrReq = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseSync(input logic [15:0] ct);
    cycleTime = ct;
    frameSyncIn = 1'b1;
    repeat (3) @(negedge clk);
    frameSyncIn = 1'b0;
    cycleTime = 16'h0BAD;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog", 32'h1, 32'h0);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid", {31'b0, hdrValid}, 32'h0);
    check("R1 quadlet", hdrQuadlet, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    sendReq(32'h8000_0000, "R1 register zero");

    // R2/R3: stamping off, full field as written
    writeReg(30'h3FAB1234);
    sendReq(32'hBFAB1234, "R3 disabled passthrough");
    repeat (3) @(negedge clk);
    check("R2 output holds", hdrQuadlet, 32'hBFAB1234);
    check("R2 valid single cycle", {31'b0, hdrValid}, 32'h0);

    // R5: enabled, no edge
    stampEn = 1'b1;
    sendReq(32'hBFABFFFF, "R5 no edge marker");

    // R4 then R8
    pulseSync(16'hBEEF);
    sendReq(32'hBFABBEEF, "R4 stamp captured");
    sendReq(32'hBFABFFFF, "R8 record cleared");

    // R6: first of two edges kept
    pulseSync(16'h1111);
    pulseSync(16'h2222);
    sendReq(32'hBFAB1111, "R6 first edge kept");

    // R7: rise detected in the same cycle as the request
    cycleTime = 16'h7777;
    frameSyncIn = 1'b1;
    repeat (2) @(negedge clk);
    sendReq(32'hBFABFFFF, "R7 coincident edge deferred");
    frameSyncIn = 1'b0;
    cycleTime = 16'h0BAD;
    repeat (2) @(negedge clk);
    sendReq(32'hBFAB7777, "R7 coincident edge next packet");

    // R9: write together with request
    regWrEn = 1'b1; regWrData = 30'h12345678;
    sendReq(32'hBFABFFFF, "R9 old contents used");
    regWrEn = 1'b0;
    sendReq(32'h9234FFFF, "R9 new contents later");

    // R10: edge recorded while disabled
    stampEn = 1'b0;
    pulseSync(16'h4321);
    stampEn = 1'b1;
    @(negedge clk);
    sendReq(32'h92344321, "R10 edge while disabled");
    stampEn = 1'b0;
    pulseSync(16'h5555);
    sendReq(32'h92345678, "R3 disabled ignores edge");

    repeat (3) @(negedge clk);
    check("scoreboard drained", expQ.size(), 32'h0);
    finishRun();
  end
endmodule